// File: doc/BRIEF.md
# PHY Management Register Write Engine

This block lets a host that only has byte-wide register writes update 16-bit registers inside an Ethernet PHY. The host does three byte writes: first the PHY register number, then the low data byte, then the high data byte. The write of the high byte starts the transfer. The engine then builds a 64-bit management write frame and shifts it out on a serial clock/data pair, with MDC and MDIO behaving in the usual station-management way.

While a frame is in flight, bit 0 of the status byte reads 1. The host polls that bit until it drops before it touches the registers again. Any register write made while the engine is busy is discarded. MDC is derived from the system clock by a parameterised half-period divider and stays low whenever the engine is idle.

Top module: `mii_wr_engine`

## Requirements
- R1: Out of reset the engine is idle. The status busy bit is 0, MDC is 0, the MDIO drive enable is 0 and MDIO rests at 1.
- R2: A write with select code 2 (high data byte) while idle sets the busy bit in the cycle after the write. The status byte carries busy in bit 0, and bits 7..1 read 0.
- R3: The frame, sent MSB first, is: 32 ones, then 01, then 01, then the 5-bit PHY address parameter, then the register number (the low 5 bits of the last select-0 byte), then 10, then the 16-bit value {high byte, low byte} (low byte from select code 1).
- R4: MDC is 0 while idle. Each MDC half period lasts HALF_DIV system clocks. The first rising MDC edge comes HALF_DIV clocks after busy rises, and a transfer has 130 MDC transitions.
- R5: MDIO changes only in the cycle in which MDC falls, apart from the cycle in which busy rises.
- R6: Busy stays high for exactly 130*HALF_DIV clocks. It falls on the MDC falling edge one full MDC period after the last data bit.
- R7: Writes to any register while busy is 1 are ignored. This includes the register number, the low byte and the high byte, and such a write neither restarts nor alters the transfer.
- R8: Writes with select code 0, 1 or 3 never start a transfer.
- R9: The MDIO drive enable is high only while busy, for exactly 128*HALF_DIV clocks per transfer, which covers the 64 frame bits. Outside that window MDIO reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte register write strobe |
| wr_sel | input | 2 | Register select: 0 register number, 1 data low, 2 data high (starts), 3 none |
| wr_data | input | 8 | Write byte |
| status_o | output | 8 | Status byte, bit 0 = busy |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data drive enable |

## Verification
The checker module watches several properties on every cycle:
- MDC stays low and the drive enable stays low whenever the engine is idle.
- MDIO holds still except on a falling MDC edge.
- A start write always raises busy.
- Each frame begins with a driven preamble one.

Other properties span a whole frame, and only the bench scenarios can show them:
- Exact bit content.
- The 130-transition and 130*HALF_DIV busy length.
- The first-rise delay.
- That writes made while busy leave no trace in the following frame.

// File: rtl/mii_wr_pkg.sv
// Shared constants and the register select encoding for the management write engine.
package mii_wr_pkg;
    typedef enum logic [1:0] {
        SEL_REGNUM  = 2'd0,
        SEL_DATA_LO = 2'd1,
        SEL_DATA_HI = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    localparam int PRE_BITS  = 32;
    localparam int CTRL_BITS = 6;   // start, opcode, turnaround
    localparam int DATA_W    = 16;
    localparam int BYTE_W    = 8;
endpackage

// File: rtl/mii_wr_regs.sv
// Host byte registers: register number and low data byte are held here.
// The start pulse is generated on a high-byte write while idle.
// Assumes writes are single-cycle strobes; all writes are dropped while busy.
module mii_wr_regs
    import mii_wr_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                busy,
    output logic [REG_AW-1:0]   reg_num,
    output logic [DATA_W-1:0]   data_word,
    output logic                start
);
    reg_sel_e           sel;
    logic [BYTE_W-1:0]  lo_q;
    logic               accept;
    logic               unused_hi;

    assign sel       = reg_sel_e'(wr_sel);
    assign accept    = wr_en && !busy;
    assign unused_hi = ^wr_data[BYTE_W-1:REG_AW];

    // Capture the register number and low byte when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_num <= '0;
            lo_q    <= '0;
        end else if (accept) begin
            if (sel == SEL_REGNUM)  reg_num <= wr_data[REG_AW-1:0];
            if (sel == SEL_DATA_LO) lo_q    <= wr_data;
        end
    end

    // The high byte is used straight from the bus together with the held low byte.
    always_comb begin
        data_word = {wr_data, lo_q};
        start     = accept && (sel == SEL_DATA_HI);
    end
endmodule

// File: rtl/mii_wr_clkgen.sv
// MDC generator: divides clk by 2*HALF_DIV while run is high.
// When run is low, MDC is held low and the divider is cleared.
// Also gives a one-cycle pulse in the cycle before MDC falls.
module mii_wr_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = run && (cnt == TOP);
    assign fall_tick = wrap && mdc;

    // Half-period counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mii_wr_shifter.sv
// Frame builder and serialiser.
// The whole write frame is loaded on start and shifted one bit per MDC fall.
// Busy is released one MDC period after the last bit.
// Assumes start only arrives while idle.
module mii_wr_shifter
    import mii_wr_pkg::*;
#(
    parameter int          PHY_AW   = 5,
    parameter int          REG_AW   = 5,
    parameter logic [4:0]  PHY_ADDR = 5'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [REG_AW-1:0]  reg_num,
    input  logic [DATA_W-1:0]  data_word,
    input  logic               fall_tick,
    output logic               busy,
    output logic               mdio,
    output logic               mdio_oe
);
    localparam int FRAME_W = PRE_BITS + CTRL_BITS + PHY_AW + REG_AW + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   falls;

    // Assemble the write frame: preamble, start, write opcode, addresses, turnaround, data.
    always_comb begin
        frame = {{PRE_BITS{1'b1}}, 2'b01, 2'b01, PHY_ADDR[PHY_AW-1:0],
                 reg_num, 2'b10, data_word};
    end

    // Load on start, shift on each MDC fall, count falls to find the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            falls <= '0;
            busy  <= 1'b0;
        end else if (start) begin
            shreg <= frame;
            falls <= '0;
            busy  <= 1'b1;
        end else if (busy && fall_tick) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b1};
            falls <= falls + 1'b1;
            if (falls == LAST_BIT) busy <= 1'b0;
        end
    end

    // Drive only while frame bits remain; otherwise rest high.
    always_comb begin
        mdio_oe = busy && (falls < LAST_BIT);
        mdio    = mdio_oe ? shreg[FRAME_W-1] : 1'b1;
    end
endmodule

// File: rtl/mii_wr_engine.sv
// Top level of the PHY management register write engine.
// Ties together the host byte registers, the MDC divider and the frame shifter.
// Exposes the busy flag in bit 0 of the status byte.
module mii_wr_engine
    import mii_wr_pkg::*;
#(
    parameter int          HALF_DIV = 4,
    parameter logic [4:0]  PHY_ADDR = 5'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    output logic [7:0]  status_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o
);
    localparam int REG_AW = 5;
    localparam int PHY_AW = 5;

    logic [REG_AW-1:0] reg_num;
    logic [DATA_W-1:0] data_word;
    logic              start;
    logic              busy;
    logic              fall_tick;

    mii_wr_regs #(.REG_AW(REG_AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .busy(busy), .reg_num(reg_num),
        .data_word(data_word), .start(start)
    );

    mii_wr_clkgen #(.HALF_DIV(HALF_DIV)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc_o), .fall_tick(fall_tick)
    );

    mii_wr_shifter #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .PHY_ADDR(PHY_ADDR)) shift_i (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_num(reg_num),
        .data_word(data_word), .fall_tick(fall_tick), .busy(busy),
        .mdio(mdio_o), .mdio_oe(mdio_oe_o)
    );

    // Status byte: busy in bit 0, the rest reserved as zero.
    always_comb status_o = {7'b0, busy};
endmodule

// File: rtl/mii_wr_engine_chk.sv
// Assertion checker for mii_wr_engine, attached with bind.
module mii_wr_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic       busy,
    input logic       mdc_o,
    input logic       mdio_o,
    input logic       mdio_oe_o
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mdc_o && !mdio_oe_o)); // R1

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && !busy) |=> busy); // R2

    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe_o && mdio_o && !mdc_o)); // R3

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc_o); // R4

    AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc_o)) |-> $stable(mdio_o)); // R5

    AST_OE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe_o |-> busy); // R9
endmodule

bind mii_wr_engine mii_wr_engine_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .busy(busy), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
);

// File: tb/mii_wr_engine_tb_top.sv
module mii_wr_engine_tb_top;
    localparam int         HALF = 4;
    localparam logic [4:0] PHY  = 5'd1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] status_o;
    logic       mdc_o, mdio_o, mdio_oe_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mii_wr_engine #(.HALF_DIV(HALF), .PHY_ADDR(PHY)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .status_o(status_o), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
    );

    function automatic logic [63:0] exp_frame(input logic [4:0] rn, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, 2'b01, PHY, rn, 2'b10, d};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    // Follow a frame from the sample after the start write until busy drops.
    task automatic observe(input logic [63:0] exp);
        logic [63:0] got = '0;
        int n = 0, nbits = 0, first_rise = -1, oe_n = 0, tog = 0, glitch = 0;
        logic pm, pd;
        chk(status_o[0] == 1'b1, "R2", "busy after start", status_o[0], 1);
        pm = mdc_o; pd = mdio_o;
        while (status_o[0] && n < 5000) begin
            if (mdc_o && !pm) begin
                if (first_rise < 0) first_rise = n;
                if (mdio_oe_o) begin got = {got[62:0], mdio_o}; nbits++; end
            end
            if (mdc_o != pm) tog++;
            if (mdio_oe_o) oe_n++;
            if (n > 0 && mdio_o != pd && !(pm && !mdc_o)) glitch++;
            pm = mdc_o; pd = mdio_o;
            n++;
            @(negedge clk);
        end
        if (mdc_o != pm) tog++;
        chk(got == exp, "R3", "frame", got, exp);
        chk(nbits == 64, "R9", "driven bits", nbits, 64);
        chk(first_rise == HALF, "R4", "first rise", first_rise, HALF);
        chk(tog == 130, "R4", "mdc transitions", tog, 130);
        chk(glitch == 0, "R5", "mdio off-edge changes", glitch, 0);
        chk(n == 130 * HALF, "R6", "busy cycles", n, 130 * HALF);
        chk(oe_n == 128 * HALF, "R9", "oe cycles", oe_n, 128 * HALF);
        chk(!mdc_o && !mdio_oe_o && mdio_o, "R6", "idle after end",
            {mdc_o, mdio_oe_o, mdio_o}, 3'b001);
    endtask

    task automatic xfer(input logic [4:0] rn, input logic [15:0] d);
        wr(2'd0, {3'b101, rn});
        wr(2'd1, d[7:0]);
        wr(2'd2, d[15:8]);
        observe(exp_frame(rn, d));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(status_o[0] == 0, "R1", "busy in reset", status_o[0], 0);
        chk({mdc_o, mdio_oe_o, mdio_o} == 3'b001, "R1", "pins in reset",
            {mdc_o, mdio_oe_o, mdio_o}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status_o == 8'h00, "R1", "status after reset", status_o, 0);

        // R8: non-start selects
        wr(2'd0, 8'h03); wr(2'd1, 8'h99); wr(2'd3, 8'hFF);
        repeat (3 * HALF) @(negedge clk);
        chk(status_o == 8'h00 && !mdc_o, "R8", "no start from sel 0/1/3",
            {status_o, mdc_o}, 0);

        // Directed corner values
        xfer(5'h1F, 16'hA5C3);
        chk(status_o[7:1] == 0, "R2", "reserved status bits", status_o[7:1], 0);
        xfer(5'h00, 16'h0000);
        xfer(5'h15, 16'hFFFF);

        // R7: writes during busy are dropped
        wr(2'd0, 8'h04); wr(2'd1, 8'h34); wr(2'd2, 8'h12);
        fork
            observe(exp_frame(5'h04, 16'h1234));
            begin
                repeat (7) @(negedge clk);
                wr(2'd0, 8'h0A);
                repeat (40) @(negedge clk);
                wr(2'd1, 8'hEE);
                repeat (100) @(negedge clk);
                wr(2'd2, 8'h77);
            end
        join
        wr(2'd2, 8'h56);
        // R7: only the high byte is new; register number and low byte kept
        observe(exp_frame(5'h04, 16'h5634));

        // Random transfers
        for (int i = 0; i < 8; i++) begin
            logic [4:0]  rn = 5'($urandom);
            logic [15:0] d  = 16'($urandom);
            xfer(rn, d);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule